// File: doc/BRIEF.md
# Video RAM to ANSI Terminal Bridge

This block is a 2 KB character display buffer on a simple processor bus. Any write that lands in its address window is stored. If the write falls inside the visible 80-column by 24-row area, it is also turned into a short byte stream for a serial text terminal. The stream can hold an escape that turns reverse video on or off, then an escape that places the cursor, then the character itself. Reads return the stored bytes with no change.

The stream is kept as short as it can be. The cursor escape is dropped when a write lands on the column just right of the previous visible write on the same row. A reverse-video escape goes out only when the attribute bit differs from the mode currently in force.

Output bytes leave through a valid/ready handshake. A bus write is accepted only while `bus_ready` is high. `bus_ready` stays low until the whole stream of the previous visible write has been sent. Reads are combinational and depend on the address and bank inputs only.

Top module: `vram_ansi_bridge`

## Requirements
- R1: The block responds only to addresses whose bits above bit 10 equal those of `BASE_ADDR` (default 16'h8000, which is 2048-aligned). A read outside the window returns 8'hFF. A write outside the window stores nothing and sends nothing.
- R2: When `bus_bank` is not zero, reads return 8'hFF and writes are ignored: nothing is stored and no byte is sent.
- R3: Every accepted write inside the window stores its byte at offset `addr[10:0]`, including offsets 1920 to 2047. A read of the window returns the stored byte unchanged, bit 7 included.
- R4: A write at an offset of 1920 or more sends no terminal byte and leaves the last-position and reverse state unchanged.
- R5: For a visible write, the row is offset/80 + 1 and the column is offset mod 80 + 1, so both are 1-based.
- R6: If bit 7 of the written byte is 1 and reverse mode is off, the stream starts with the bytes 1B 5B 30 37 6D (ESC "[07m"), and reverse mode turns on.
- R7: If bit 7 is 0 and reverse mode is on, the stream starts with 1B 5B 30 30 6D (ESC "[00m"), and reverse mode turns off.
- R8: If the row equals the last row and the column equals the last column + 1, no position escape is sent. Otherwise the next bytes are ESC "[" row ";" col "H". Row and column are written in decimal ASCII with no leading zero. The last row and column then take the written position.
- R9: The final byte of every stream is the written byte with bit 7 cleared.
- R10: After reset, `bus_ready` is 1, `tx_valid` is 0, the last position is row 0 / column 0 and reverse mode is off. The first visible write therefore always sends a position escape.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds steady. `bus_ready` is 0 from the cycle after a visible write is accepted until its last byte is taken. A write is taken only on a clock edge where `bus_wr` and `bus_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write request, held until accepted |
| bus_wdata | input | 8 | Write data; bit 7 is the reverse-video attribute |
| bus_bank | input | 2 | Bank select; the block is active only when it is 0 |
| bus_rdata | output | 8 | Read data for the current address (8'hFF when not selected) |
| bus_ready | output | 1 | High when a write can be accepted |
| tx_data | output | 8 | Terminal byte |
| tx_valid | output | 1 | `tx_data` holds a byte to send |
| tx_ready | input | 1 | Terminal side takes the byte this cycle |

## Verification
Reverse-video switching and cursor placement can both be needed by one write. The bench provokes this with random bytes whose bit 7 flips at random, mixed with writes that are either sequential or jump to a new place. Each stream is then compared byte by byte with a bench model, which must show the attribute escape before the position escape. A second overlap is a new bus write that arrives while the previous stream is still throttled by a random `tx_ready`. The bench holds `tx_ready` low and checks that `bus_ready` stays low and `tx_data` stays steady. No byte may be lost or reordered once the stall ends.

// File: rtl/vab_pkg.sv
package vab_pkg;
  localparam int SEQ_MAX = 14;  // 5 attribute + 8 position + 1 char
  localparam int POS_W   = 7;

  localparam logic [7:0] K_ESC  = 8'h1B;
  localparam logic [7:0] K_LBR  = 8'h5B;
  localparam logic [7:0] K_SEMI = 8'h3B;
  localparam logic [7:0] K_H    = 8'h48;
  localparam logic [7:0] K_M    = 8'h6D;
  localparam logic [7:0] K_ZERO = 8'h30;
  localparam logic [7:0] K_SEVN = 8'h37;

  typedef struct packed {
    logic [SEQ_MAX-1:0][7:0] b;
    logic [3:0]              n;
  } seq_t;

  // tens digit of a 1..99 value
  function automatic logic [POS_W-1:0] tens_of(input logic [POS_W-1:0] v);
    return v / POS_W'(10);
  endfunction

  function automatic logic [7:0] ascii_of(input logic [POS_W-1:0] d);
    return K_ZERO + {1'b0, d};
  endfunction

  // assemble the whole terminal stream for one visible write
  function automatic seq_t build_seq(input logic rev_on, input logic rev_off,
                                     input logic pos, input logic [POS_W-1:0] row,
                                     input logic [POS_W-1:0] col, input logic [7:0] ch);
    seq_t s;
    int   k;
    logic [POS_W-1:0] t;
    s = '0;
    k = 0;
    if (rev_on || rev_off) begin
      s.b[k]   = K_ESC;
      s.b[k+1] = K_LBR;
      s.b[k+2] = K_ZERO;
      s.b[k+3] = rev_on ? K_SEVN : K_ZERO;
      s.b[k+4] = K_M;
      k += 5;
    end
    if (pos) begin
      s.b[k] = K_ESC; k++;
      s.b[k] = K_LBR; k++;
      t = tens_of(row);
      if (t != 0) begin s.b[k] = ascii_of(t); k++; end
      s.b[k] = ascii_of(row - t * POS_W'(10)); k++;
      s.b[k] = K_SEMI; k++;
      t = tens_of(col);
      if (t != 0) begin s.b[k] = ascii_of(t); k++; end
      s.b[k] = ascii_of(col - t * POS_W'(10)); k++;
      s.b[k] = K_H; k++;
    end
    s.b[k] = {1'b0, ch[6:0]};
    k++;
    s.n = 4'(k);
    return s;
  endfunction
endpackage

// File: rtl/vab_decode.sv
module vab_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_LG = 11,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              hit,
  output logic [WIN_LG-1:0] off
);
  assign off = addr[WIN_LG-1:0];
  assign hit = (addr[ADDR_W-1:WIN_LG] == BASE_ADDR[ADDR_W-1:WIN_LG]) && (bank == '0);
endmodule

// File: rtl/vab_vram.sv
module vab_vram #(
  parameter int WIN_LG = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WIN_LG-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << WIN_LG;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
  assign rdata = mem[addr];
endmodule

// File: rtl/vab_emitter.sv
module vab_emitter
  import vab_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  seq_t       seq_in,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy
);
  logic [SEQ_MAX-1:0][7:0] buf_q;
  logic [3:0]              idx_q, len_q;
  logic                    busy_q;
  logic                    last_byte;

  assign last_byte = (idx_q == len_q - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      buf_q  <= seq_in.b;
      len_q  <= seq_in.n;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tx_ready) begin
      if (last_byte) busy_q <= 1'b0;
      else           idx_q  <= idx_q + 4'd1;
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = buf_q[idx_q];
  assign busy     = busy_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11
  AST_TX_ASCII: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_data[7]); // R9
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R11
  AST_SEQ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (seq_in.n != 4'd0) && (seq_in.n <= 4'(SEQ_MAX))); // R8
endmodule

// File: rtl/vram_ansi_bridge.sv
module vram_ansi_bridge
  import vab_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LG = 11,
  parameter int BANK_W = 2,
  parameter int COLS   = 80,
  parameter int ROWS   = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [1:0]        bus_bank,
  output logic [7:0]        bus_rdata,
  output logic              bus_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  localparam int VIS_N = COLS * ROWS;
  localparam logic [WIN_LG-1:0] VIS_LIM  = WIN_LG'(VIS_N);
  localparam logic [WIN_LG-1:0] COLS_W   = WIN_LG'(COLS);

  logic              hit, wr_acc, vis, load, busy;
  logic [WIN_LG-1:0] off, quo, rem;
  logic [7:0]        mem_rd;
  logic [POS_W-1:0]  row_n, col_n, last_row_q, last_col_q;
  logic              rev_q, rev_on, rev_off, need_pos;
  seq_t              seq;

  vab_decode #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG), .BANK_W(BANK_W), .BASE_ADDR(BASE_ADDR))
    u_dec (.addr(bus_addr), .bank(bus_bank), .hit(hit), .off(off));

  vab_vram #(.WIN_LG(WIN_LG))
    u_ram (.clk(clk), .we(wr_acc), .addr(off), .wdata(bus_wdata), .rdata(mem_rd));

  assign wr_acc    = bus_wr && bus_ready && hit;
  assign vis       = off < VIS_LIM;
  assign load      = wr_acc && vis;
  assign bus_ready = !busy;
  assign bus_rdata = hit ? mem_rd : 8'hFF;

  // 1-based screen position
  assign quo   = off / COLS_W;
  assign rem   = off - quo * COLS_W;
  assign row_n = POS_W'(quo) + POS_W'(1);
  assign col_n = POS_W'(rem) + POS_W'(1);

  assign need_pos = !((row_n == last_row_q) && ({1'b0, col_n} == {1'b0, last_col_q} + 8'd1));
  assign rev_on   = bus_wdata[7] && !rev_q;
  assign rev_off  = !bus_wdata[7] && rev_q;
  assign seq      = build_seq(rev_on, rev_off, need_pos, row_n, col_n, bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_row_q <= '0;
      last_col_q <= '0;
      rev_q      <= 1'b0;
    end else if (load) begin
      last_row_q <= row_n;
      last_col_q <= col_n;
      rev_q      <= bus_wdata[7];
    end
  end

  vab_emitter u_emit (.clk(clk), .rst_n(rst_n), .load(load), .seq_in(seq),
                      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy));

  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_bank != 2'd0) |-> !load); // R2
  AST_ATTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load && (rev_on || rev_off) |=> tx_valid && (tx_data == K_ESC)); // R6
  AST_REV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rev_q == $past(bus_wdata[7])); // R7
  AST_HIDDEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && !vis |=> !tx_valid); // R4
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (row_n >= 1) && (row_n <= POS_W'(ROWS)) && (col_n >= 1) && (col_n <= POS_W'(COLS))); // R5
endmodule

// File: tb/vram_ansi_bridge_bench.sv
module vram_ansi_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  bus_bank = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  always #4 clk = ~clk;

  vram_ansi_bridge u_vram_ansi_bridge (.*);

  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  int          ready_mode = 0;  // 0 random, 1 hold low, 2 always high
  logic [7:0]  expq[$];
  logic [7:0]  shadow [2048];
  bit          written [2048];
  int          m_row = 0, m_col = 0;
  bit          m_rev = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void push_str(input string s);
    for (int i = 0; i < s.len(); i++) expq.push_back(s[i]);
  endfunction

  // reference model of one bus write
  function automatic void model_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] bk);
    int o, r, c;
    if (bk != 0 || a[15:11] != 5'b10000) return;
    o = int'(a[10:0]);
    shadow[o] = d;
    written[o] = 1;
    if (o >= 1920) return;
    r = 1; c = o;
    while (c >= 80) begin c -= 80; r++; end
    c = c + 1;
    if (d[7] && !m_rev) begin expq.push_back(8'h1B); push_str("[07m"); end
    if (!d[7] && m_rev) begin expq.push_back(8'h1B); push_str("[00m"); end
    if (!(r == m_row && c == m_col + 1)) begin
      expq.push_back(8'h1B);
      push_str($sformatf("[%0d;%0dH", r, c));
    end
    expq.push_back({1'b0, d[6:0]});
    m_rev = d[7]; m_row = r; m_col = c;
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] bk);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_bank = bk; bus_wr = 1'b1;
    model_write(a, d, bk);
    @(negedge clk);
    bus_wr = 1'b0; bus_bank = 2'd0;
  endtask

  task automatic bus_read(input string req, input logic [15:0] a, input logic [1:0] bk,
                          input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_bank = bk;
    #1;
    check(req, bus_rdata, exp);
    bus_bank = 2'd0;
  endtask

  task automatic drain();
    int guard = 0;
    @(negedge clk);
    while ((tx_valid || expq.size() != 0) && guard < 2000) begin @(negedge clk); guard++; end
    check("R8 stream drained", expq.size(), 0);
  endtask

  // terminal side: drive ready, compare every byte that will be taken
  always @(negedge clk) begin
    if (ready_mode == 1) tx_ready = 1'b0;
    else if (ready_mode == 2) tx_ready = 1'b1;
    else tx_ready = ($urandom_range(0, 9) < 7);
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) check("R8 unexpected byte", tx_data, 8'hxx);
      else check("R8 R9 stream byte", tx_data, expq.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_b;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", bus_ready, 1);
    check("R10 no byte after reset", tx_valid, 0);

    // R10 R8: first write places cursor at 1;1
    bus_write(16'h8000, "A", 0);
    drain();
    // R8: next column on same row -> character only
    bus_write(16'h8001, "B", 0);
    drain();
    // R6: attribute on plus a jump
    bus_write(16'h8000 + 16'd85, 8'hC3, 0);
    drain();
    // R6: stays on, sequential -> char only
    bus_write(16'h8000 + 16'd86, 8'hC4, 0);
    drain();
    // R7: attribute off
    bus_write(16'h8000 + 16'd87, 8'h45, 0);
    drain();
    // R5: last visible cell row 24 col 80, then wrap to next row start
    bus_write(16'h8000 + 16'd1919, "Z", 0);
    drain();
    bus_write(16'h8000 + 16'd80, "W", 0);
    drain();
    bus_write(16'h8000 + 16'd79, "E", 0);
    drain();
    // R4: hidden region store, no output, state untouched
    bus_write(16'h8000 + 16'd1920, 8'h9F, 0);
    repeat (4) begin @(negedge clk); check("R4 hidden write silent", tx_valid, 0); end
    bus_read("R3 hidden byte readback", 16'h8000 + 16'd1920, 0, 8'h9F);
    bus_read("R3 bit7 readback", 16'h8000 + 16'd85, 0, 8'hC3);
    // R2: other bank
    bus_write(16'h8001, 8'h11, 2'd1);
    repeat (4) begin @(negedge clk); check("R2 bank write silent", tx_valid, 0); end
    bus_read("R2 bank read", 16'h8001, 2'd2, 8'hFF);
    bus_read("R2 bank write ignored", 16'h8001, 0, "B");
    // R1: outside the window
    bus_write(16'h8800, 8'h22, 0);
    bus_write(16'h7FFF, 8'h33, 0);
    repeat (3) begin @(negedge clk); check("R1 outside write silent", tx_valid, 0); end
    bus_read("R1 outside read", 16'h8800, 0, 8'hFF);
    bus_read("R1 no alias", 16'h8000, 0, "A");
    // R11: stall with terminal holding off
    ready_mode = 1;
    bus_write(16'h8000 + 16'd500, "Q", 0);
    hold_b = tx_data;
    repeat (5) begin
      @(negedge clk);
      check("R11 bus stalled", bus_ready, 0);
      check("R11 data held", tx_data, hold_b);
    end
    ready_mode = 0;
    drain();

    // random phase
    for (int i = 0; i < 600; i++) begin
      int sel, o;
      logic [15:0] a;
      logic [1:0]  bk;
      sel = $urandom_range(0, 99);
      if (sel < 50) o = (m_row == 0) ? 0 : ((m_row - 1) * 80 + m_col) % 1920;
      else if (sel < 85) o = $urandom_range(0, 1919);
      else o = $urandom_range(0, 2047);
      a = 16'h8000 + 16'(o);
      if ($urandom_range(0, 19) == 0) a = 16'($urandom_range(0, 65535));
      bk = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      bus_write(a, 8'($urandom_range(0, 255)), bk);
      if ($urandom_range(0, 7) == 0) begin
        int ro;
        ro = $urandom_range(0, 2047);
        if (written[ro]) bus_read("R3 random readback", 16'h8000 + 16'(ro), 0, shadow[ro]);
      end
    end
    ready_mode = 2;
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule